// File: doc/BRIEF.md
# SD Command Line Engine

This block drives the single command wire of an SD/MMC card interface. A one-cycle start pulse hands it a command index and a 32-bit argument. It builds the 48-bit command frame, computes the CRC7 for it, and shifts the frame out one bit per bus-clock enable. After the frame it can do one of two things. It can release the line and hunt for the card's reply. Or, when no reply is expected, it can keep the line high for eight extra bus clocks so the card has clocks to finish its internal work.

Replies come in two lengths: a 48-bit short form and a 136-bit long form. The engine captures the reply, checks its CRC7 unless told not to, and checks the transmission bit and the end bit. The result appears as four 32-bit response words and a status word whose bit positions are fixed, because software decodes them. A 16-bit timeout, counted in bus clocks, ends the hunt when the card stays silent. All line activity advances only on cycles where `bus_tick` is high. The system clock itself is free-running.

Top module: `sd_cmd_engine`

## Requirements
- R1: A frame is sent MSB first as start bit 0, transmission bit 1, `cmd_index[5:0]`, the 32-bit argument, CRC7, end bit 1. Index bits 7:6 are not sent. Each bit is driven with `cmd_oe` high and moves on only at a clock edge where `bus_tick` is high. The first bit appears in the cycle after `start` is accepted.
- R2: The frame CRC7 uses the generator x^7+x^3+1 with a zero initial value. It covers the first 40 frame bits.
- R3: When `want_resp` is 0 and `pad_idle` is 1, the engine drives exactly 8 more bus clocks of logic 1 after the end bit. When `pad_idle` is 0, or when `want_resp` is 1, it adds no such bits.
- R4: While hunting, the line is sampled on each `bus_tick`, and a sampled 0 is taken as the reply start bit. If `resp_timeout` consecutive samples are 1, the hunt ends; a value of 0 acts as 1. Status bit 14 is then set, bits 16 and 15 stay 0, and the response words keep their previous contents.
- R5: For a short reply (received bits 47..0), `resp0` is set to bits 39:8 and `resp1` to `resp3` are set to 0.
- R6: For a long reply (received bits 135..0), `resp0` is set to bits 31:0, `resp1` to bits 63:32, `resp2` to bits 95:64 and `resp3` to bits 127:96.
- R7: The reply CRC is computed over bits 47:8 for a short reply and over bits 127:8 for a long reply. It is compared with bits 7:1. A mismatch sets status bit 16 unless `skip_crc` was set at start.
- R8: Status bit 15 is set when the received transmission bit (bit 46 of a short reply, bit 134 of a long reply) is 1, or when the end bit (bit 0) is 0.
- R9: `busy` rises in the cycle after an accepted `start`. At that moment status bits 16:14 are cleared. `busy` falls in the second cycle after the tick edge that samples the reply end bit, the last frame or pad bit, or the timing-out sample. Results are valid when `busy` falls and stay unchanged while idle.
- R10: `status_word` carries reply-CRC error at bit 16, reply-format error at bit 15, timeout at bit 14, command-phase busy at bit 3 and overall busy at bit 0. All other bits are 0.
- R11: A `start` pulse while `busy` is high is ignored. The frame being sent and the result are unaffected.
- R12: After reset, `busy`, `cmd_oe`, `status_word` and all four response words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_tick | input | 1 | Bus-clock enable; line activity advances only on these cycles |
| start | input | 1 | One-cycle request to begin a command |
| cmd_index | input | 8 | Command index; bits 5:0 are sent |
| cmd_arg | input | ARG_W | Command argument |
| want_resp | input | 1 | Hunt for and capture a reply |
| long_resp | input | 1 | Reply is 136 bits instead of 48 |
| skip_crc | input | 1 | Suppress the reply CRC error flag |
| pad_idle | input | 1 | Append 8 high bus clocks when no reply is wanted |
| resp_timeout | input | TO_W | Reply hunt limit in bus clocks |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Driven command line value |
| cmd_oe | output | 1 | Command line drive enable |
| resp0 | output | 32 | Response word 0 (least significant) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 (most significant) |
| status_word | output | 32 | Error and busy flags |
| busy | output | 1 | Transaction in progress |

## Verification
The bound checker watches, on every cycle, the invariants that hold regardless of what the card sends. The driven line holds its value between ticks. Drive never happens while idle. `busy` rises only on an accepted start and falls one cycle after the result is written. Flags clear at each start and stay still while idle. The timeout flag never appears together with the CRC or format flags. The cycle-level checks cannot show whether the frame bits, the CRC7 values, the pad length, the word order of long replies or the timeout boundary are right. Only the bench scenarios show these, by comparing the serialised frame and the captured words against values the bench computes itself.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_SPAN   = 120;
  localparam int WORD_W     = 32;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_TX   = 2'd1,
    ENG_RX   = 2'd2,
    ENG_FIN  = 2'd3
  } eng_state_e;

  // CRC7 (x^7 + x^3 + 1), zero seed, over the top nbits of msg, MSB first.
  function automatic logic [6:0] crc7_calc(input logic [CRC_SPAN-1:0] msg,
                                           input int nbits);
    logic [6:0] r;
    logic       fb;
    r = 7'd0;
    for (int i = 0; i < CRC_SPAN; i++) begin
      if (i < nbits) begin
        fb = msg[CRC_SPAN-1-i] ^ r[6];
        r  = {r[5:0], 1'b0};
        if (fb) r = r ^ 7'h09;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W    = 32,
  parameter int PAD_CLKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [5:0]       idx6,
  input  logic [ARG_W-1:0] arg,
  input  logic             pad_en,
  output logic             line_o,
  output logic             line_oe,
  output logic             done
);

  localparam int HEAD_W  = ARG_W + 8;
  localparam int FRAME_W = ARG_W + 16;
  localparam int CNT_W   = $clog2(FRAME_W + PAD_CLKS + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               active;
  logic [HEAD_W-1:0]  head;
  logic [6:0]         head_crc;

  assign head     = {1'b0, 1'b1, idx6, arg};
  assign head_crc = crc7_calc({head, {(CRC_SPAN-HEAD_W){1'b0}}}, HEAD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      left   <= '0;
      active <= 1'b0;
    end else if (load) begin
      shreg  <= {head, head_crc, 1'b1};
      left   <= pad_en ? CNT_W'(FRAME_W + PAD_CLKS) : CNT_W'(FRAME_W);
      active <= 1'b1;
    end else if (active && tick) begin
      shreg <= {shreg[FRAME_W-2:0], 1'b1};
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) active <= 1'b0;
    end
  end

  assign line_o  = shreg[FRAME_W-1];
  assign line_oe = active;
  assign done    = active && tick && (left == CNT_W'(1));

endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx
  import sd_cmd_pkg::*;
#(
  parameter int TO_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 arm,
  input  logic                 long_mode,
  input  logic [TO_W-1:0]      to_limit,
  input  logic                 line_i,
  output logic                 done,
  output logic                 timed_out,
  output logic [LONG_BITS-1:0] frame
);

  localparam logic [1:0] PH_OFF  = 2'd0;
  localparam logic [1:0] PH_HUNT = 2'd1;
  localparam logic [1:0] PH_TAKE = 2'd2;

  logic [1:0]      phase;
  logic [TO_W-1:0] waited;
  logic [7:0]      left;
  logic [TO_W:0]   next_wait;
  logic            limit_hit;
  logic            last_bit;

  assign next_wait = {1'b0, waited} + (TO_W+1)'(1);
  assign limit_hit = next_wait >= {1'b0, to_limit};
  assign last_bit  = (left == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OFF;
      waited    <= '0;
      left      <= '0;
      timed_out <= 1'b0;
      frame     <= '0;
    end else if (arm) begin
      phase     <= PH_HUNT;
      waited    <= '0;
      timed_out <= 1'b0;
      frame     <= '0;
    end else if (tick) begin
      case (phase)
        PH_HUNT: begin
          if (!line_i) begin
            frame <= {frame[LONG_BITS-2:0], 1'b0};
            left  <= long_mode ? 8'(LONG_BITS-1) : 8'(SHORT_BITS-1);
            phase <= PH_TAKE;
          end else if (limit_hit) begin
            timed_out <= 1'b1;
            phase     <= PH_OFF;
          end else begin
            waited <= next_wait[TO_W-1:0];
          end
        end
        PH_TAKE: begin
          frame <= {frame[LONG_BITS-2:0], line_i};
          left  <= left - 8'd1;
          if (last_bit) phase <= PH_OFF;
        end
        default: ;
      endcase
    end
  end

  assign done = tick && !arm &&
                (((phase == PH_HUNT) && line_i && limit_hit) ||
                 ((phase == PH_TAKE) && last_bit));

endmodule

// File: rtl/sd_cmd_resp_eval.sv
module sd_cmd_resp_eval
  import sd_cmd_pkg::*;
(
  input  logic                 long_mode,
  input  logic [LONG_BITS-1:0] frame,
  output logic [4*WORD_W-1:0]  words,
  output logic                 crc_bad,
  output logic                 form_bad
);

  logic [6:0] short_crc;
  logic [6:0] long_crc;

  assign short_crc = crc7_calc({frame[SHORT_BITS-1:8], {(CRC_SPAN-SHORT_BITS+8){1'b0}}},
                               SHORT_BITS - 8);
  assign long_crc  = crc7_calc(frame[127:8], CRC_SPAN);

  always_comb begin
    if (long_mode) begin
      words    = frame[4*WORD_W-1:0];
      crc_bad  = long_crc != frame[7:1];
      form_bad = frame[LONG_BITS-2] | ~frame[0];
    end else begin
      words    = {{(3*WORD_W){1'b0}}, frame[39:8]};
      crc_bad  = short_crc != frame[7:1];
      form_bad = frame[SHORT_BITS-2] | ~frame[0];
    end
  end

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int ARG_W    = 32,
  parameter int TO_W     = 16,
  parameter int PAD_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic              start,
  input  logic [7:0]        cmd_index,
  input  logic [ARG_W-1:0]  cmd_arg,
  input  logic              want_resp,
  input  logic              long_resp,
  input  logic              skip_crc,
  input  logic              pad_idle,
  input  logic [TO_W-1:0]   resp_timeout,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic [WORD_W-1:0] resp0,
  output logic [WORD_W-1:0] resp1,
  output logic [WORD_W-1:0] resp2,
  output logic [WORD_W-1:0] resp3,
  output logic [31:0]       status_word,
  output logic              busy
);

  eng_state_e state;
  logic want_q, long_q, skip_q;
  logic crc_f, form_f, to_f;
  logic [4*WORD_W-1:0] resp_q;

  // named internal events (also used by the checker)
  logic load_tx, tx_done, rx_arm, rx_done, fin_evt, cmd_busy;
  logic rx_timed_out;
  logic [LONG_BITS-1:0] rx_frame;
  logic [4*WORD_W-1:0]  eval_words;
  logic eval_crc_bad, eval_form_bad;

  assign load_tx  = (state == ENG_IDLE) && start;
  assign rx_arm   = (state == ENG_TX) && tx_done && want_q;
  assign fin_evt  = (state == ENG_FIN);
  assign cmd_busy = (state == ENG_TX) || (state == ENG_RX);

  sd_cmd_tx #(.ARG_W(ARG_W), .PAD_CLKS(PAD_CLKS)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bus_tick),
    .load    (load_tx),
    .idx6    (cmd_index[5:0]),
    .arg     (cmd_arg),
    .pad_en  (pad_idle & ~want_resp),
    .line_o  (cmd_out),
    .line_oe (cmd_oe),
    .done    (tx_done)
  );

  sd_cmd_rx #(.TO_W(TO_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bus_tick),
    .arm       (rx_arm),
    .long_mode (long_q),
    .to_limit  (resp_timeout),
    .line_i    (cmd_in),
    .done      (rx_done),
    .timed_out (rx_timed_out),
    .frame     (rx_frame)
  );

  sd_cmd_resp_eval u_eval (
    .long_mode (long_q),
    .frame     (rx_frame),
    .words     (eval_words),
    .crc_bad   (eval_crc_bad),
    .form_bad  (eval_form_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      want_q <= 1'b0;
      long_q <= 1'b0;
      skip_q <= 1'b0;
      crc_f  <= 1'b0;
      form_f <= 1'b0;
      to_f   <= 1'b0;
      resp_q <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            state  <= ENG_TX;
            want_q <= want_resp;
            long_q <= long_resp;
            skip_q <= skip_crc;
            crc_f  <= 1'b0;
            form_f <= 1'b0;
            to_f   <= 1'b0;
          end
        end
        ENG_TX: begin
          if (tx_done) state <= want_q ? ENG_RX : ENG_FIN;
        end
        ENG_RX: begin
          if (rx_done) state <= ENG_FIN;
        end
        ENG_FIN: begin
          state <= ENG_IDLE;
          if (want_q) begin
            if (rx_timed_out) begin
              to_f <= 1'b1;
            end else begin
              crc_f  <= eval_crc_bad & ~skip_q;
              form_f <= eval_form_bad;
              resp_q <= eval_words;
            end
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy  = (state != ENG_IDLE);
  assign resp0 = resp_q[WORD_W-1:0];
  assign resp1 = resp_q[2*WORD_W-1:WORD_W];
  assign resp2 = resp_q[3*WORD_W-1:2*WORD_W];
  assign resp3 = resp_q[4*WORD_W-1:3*WORD_W];
  assign status_word = {15'd0, crc_f, form_f, to_f, 10'd0, cmd_busy, 2'd0, busy};

endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_tick,
  input logic        start,
  input logic        busy,
  input logic        cmd_oe,
  input logic        cmd_out,
  input logic [31:0] status_word,
  input logic        tx_done,
  input logic        rx_done,
  input logic        fin_evt
);

  assert_oe_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  assert_bit_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && $past(cmd_oe) && !$past(bus_tick)) |-> $stable(cmd_out));

  assert_done_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done || rx_done) |-> bus_tick);

  assert_rise_needs_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (status_word[16:14] == 3'b000));

  assert_idle_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(status_word[16:14]));

  assert_rx_to_fin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> fin_evt);

  assert_fin_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> !busy);

  assert_timeout_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[14] |-> (!status_word[16] && !status_word[15]));

endmodule

bind sd_cmd_engine sd_cmd_engine_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_tick    (bus_tick),
  .start       (start),
  .busy        (busy),
  .cmd_oe      (cmd_oe),
  .cmd_out     (cmd_out),
  .status_word (status_word),
  .tx_done     (tx_done),
  .rx_done     (rx_done),
  .fin_evt     (fin_evt)
);

// File: tb/test_sd_cmd_engine.sv
module test_sd_cmd_engine;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_tick = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic        want_resp = 1'b0, long_resp = 1'b0, skip_crc = 1'b0, pad_idle = 1'b0;
  logic [15:0] resp_timeout = '0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy;
  logic [31:0] resp0, resp1, resp2, resp3, status_word;

  sd_cmd_engine i_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .start(start),
    .cmd_index(cmd_index), .cmd_arg(cmd_arg), .want_resp(want_resp),
    .long_resp(long_resp), .skip_crc(skip_crc), .pad_idle(pad_idle),
    .resp_timeout(resp_timeout), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .resp0(resp0), .resp1(resp1), .resp2(resp2),
    .resp3(resp3), .status_word(status_word), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [47:0]  frame;
    int           pads;
    logic [127:0] words;
    logic [2:0]   flags;  // {crc, format, timeout}
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  logic [127:0] last_words = '0;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // CRC7 by polynomial long division; message right-aligned in m, n bits long
  function automatic logic [6:0] bcrc(input logic [119:0] m, input int n);
    logic [127:0] work;
    work = '0;
    for (int i = 0; i < n; i++) work[i+7] = m[i];
    for (int i = n + 6; i >= 7; i--)
      if (work[i]) work[i -: 8] = work[i -: 8] ^ 8'h89;
    return work[6:0];
  endfunction

  // bus-clock enable: one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      bus_tick = 1'b1;
      @(negedge clk);
      bus_tick = 1'b0;
    end
  end

  task automatic wait_tick_edge();
    do @(posedge clk); while (!bus_tick);
  endtask

  // monitor: collect line bits, compare at busy fall
  initial begin
    logic [47:0] fr;
    int nb, padn, padbad;
    logic prev_busy;
    exp_t e;
    fr = '0; nb = 0; padn = 0; padbad = 0; prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_oe && bus_tick) begin
        if (nb < 48) fr = {fr[46:0], cmd_out};
        else begin
          padn++;
          if (cmd_out !== 1'b1) padbad++;
        end
        nb++;
      end
      if (prev_busy && !busy) begin
        if (sb_q.size() == 0) begin
          chk("R9 unexpected completion", 128'd1, 128'd0);
        end else begin
          e = sb_q.pop_front();
          chk({"R1 R2 frame ", e.tag}, {80'd0, fr}, {80'd0, e.frame});
          chk({"R3 pad count ", e.tag}, 128'(padn), 128'(e.pads));
          chk({"R3 pad level ", e.tag}, 128'(padbad), 128'd0);
          chk({"R5 R6 words ", e.tag}, {resp3, resp2, resp1, resp0}, e.words);
          chk({"R7 R8 R4 flags ", e.tag}, 128'(status_word[16:14]), 128'(e.flags));
          chk({"R10 idle busy bits ", e.tag}, 128'({status_word[3], status_word[0]}), 128'd0);
        end
        fr = '0; nb = 0; padn = 0; padbad = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic issue(input logic [7:0] idx, input logic [31:0] arg,
                       input bit want, input bit lng, input bit skip, input bit pad,
                       input logic [15:0] to, input bit respond, input int delay,
                       input bit bad_crc, input bit bad_tx, input bit bad_end,
                       input logic [119:0] payload, input bit poke, input string tag);
    exp_t e;
    logic [39:0]  head;
    logic [47:0]  r48;
    logic [135:0] r136;
    int eff_to, nbits;
    head = {1'b0, 1'b1, idx[5:0], arg};
    e.frame = {head, bcrc({80'd0, head}, 40), 1'b1};
    e.pads  = (!want && pad) ? 8 : 0;
    e.tag   = tag;
    r48 = {1'b0, bad_tx, idx[5:0], payload[31:0], 8'h00};
    r48[7:1] = bcrc({80'd0, r48[47:8]}, 40) ^ {6'd0, bad_crc};
    r48[0] = ~bad_end;
    r136 = {1'b0, bad_tx, 6'h3F, payload, 8'h00};
    r136[7:1] = bcrc(payload, 120) ^ {6'd0, bad_crc};
    r136[0] = ~bad_end;
    eff_to = (to == 16'd0) ? 1 : int'(to);
    if (!want) begin
      e.flags = 3'b000;
      e.words = last_words;
    end else if (!respond || delay >= eff_to) begin
      e.flags = 3'b001;
      e.words = last_words;
    end else begin
      e.flags = {bad_crc & ~skip, bad_tx | bad_end, 1'b0};
      e.words = lng ? r136[127:0] : {96'd0, payload[31:0]};
    end
    last_words = e.words;
    sb_q.push_back(e);

    @(negedge clk);
    cmd_index = idx; cmd_arg = arg; want_resp = want; long_resp = lng;
    skip_crc = skip; pad_idle = pad; resp_timeout = to; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R9 busy rises ", tag}, 128'(busy), 128'd1);
    chk({"R10 busy bits ", tag}, 128'({status_word[3], status_word[0]}), 128'd3);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_index = ~idx; cmd_arg = ~arg; start = 1'b1;  // R11: must be ignored
      @(negedge clk);
      start = 1'b0;
      chk({"R11 still busy ", tag}, 128'(busy), 128'd1);
    end
    if (want && respond && delay < eff_to) begin
      wait (!cmd_oe);
      #1;
      for (int k = 0; k < delay; k++) begin
        wait_tick_edge();
        #1;
      end
      nbits = lng ? 136 : 48;
      for (int b = nbits - 1; b >= 0; b--) begin
        cmd_in = lng ? r136[b] : r48[b];
        wait_tick_edge();
        #1;
      end
      cmd_in = 1'b1;
    end
    wait (!busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset busy", 128'(busy), 128'd0);
    chk("R12 reset oe", 128'(cmd_oe), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset status", 128'(status_word), 128'd0);
    chk("R12 reset words", {resp3, resp2, resp1, resp0}, 128'd0);

    // R1 R2 R3: plain command, no pad
    issue(8'h00, 32'h0000_0000, 0, 0, 0, 0, 16'd10, 0, 0, 0, 0, 0, '0, 0, "nopad");
    // R1 R3: upper index bits dropped, padding present
    issue(8'hC5, 32'hDEAD_BEEF, 0, 0, 0, 1, 16'd10, 0, 0, 0, 0, 0, '0, 0, "pad");
    // R5 R7: good short reply
    issue(8'h11, 32'h1234_5678, 1, 0, 0, 0, 16'd16, 1, 2, 0, 0, 0, 120'h0A0B0C0D, 0, "short");
    // R3: pad ignored when a reply is wanted
    issue(8'h0D, 32'h0000_0001, 1, 0, 0, 1, 16'd16, 1, 1, 0, 0, 0, 120'hCAFEF00D, 0, "padign");
    // R7: bad CRC flagged
    issue(8'h12, 32'hA5A5_5A5A, 1, 0, 0, 0, 16'd16, 1, 0, 1, 0, 0, 120'h11223344, 0, "crcbad");
    // R7: bad CRC suppressed
    issue(8'h12, 32'hA5A5_5A5A, 1, 0, 1, 0, 16'd16, 1, 0, 1, 0, 0, 120'h55667788, 0, "crcskip");
    // R8: end bit low, transmission bit high
    issue(8'h07, 32'h0F0F_0F0F, 1, 0, 0, 0, 16'd16, 1, 1, 0, 0, 1, 120'h9999AAAA, 0, "endbad");
    issue(8'h07, 32'h0F0F_0F0F, 1, 0, 0, 0, 16'd16, 1, 1, 0, 1, 0, 120'h1357_9BDF, 0, "txbad");
    // R6: long reply word order, then bad CRC on long
    issue(8'h02, 32'h0, 1, 1, 0, 0, 16'd16, 1, 3, 0, 0, 0,
          120'hF1E2D3C4B5A69788_796A5B4C3D2E1F, 0, "long");
    issue(8'h09, 32'h0001_0000, 1, 1, 0, 0, 16'd16, 1, 0, 1, 0, 0,
          120'h0123456789ABCDEF_FEDCBA98765432, 0, "longcrc");
    // R4: timeout boundary
    issue(8'h03, 32'h0, 1, 0, 0, 0, 16'd3, 1, 2, 0, 0, 0, 120'h7777_1111, 0, "to_edge_ok");
    issue(8'h03, 32'h0, 1, 0, 0, 0, 16'd3, 1, 3, 0, 0, 0, 120'h2222_3333, 0, "to_edge_fire");
    issue(8'h03, 32'h0, 1, 0, 0, 0, 16'd0, 0, 0, 0, 0, 0, '0, 0, "to_zero");
    // R9: flags cleared by a following command without reply
    issue(8'h00, 32'h0, 0, 0, 0, 0, 16'd5, 0, 0, 0, 0, 0, '0, 0, "clear");
    // R11: start while busy ignored
    issue(8'h19, 32'h8000_0001, 1, 0, 0, 0, 16'd16, 1, 1, 0, 0, 0, 120'h4444_5555, 1, "poke");

    chk("R9 queue drained", 128'(sb_q.size()), 128'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule